// File: doc/BRIEF.md
# Prefix Address Generator

This block forms the effective data address for the register-indirect and post-increment operand modes of a processor with 16-bit instructions and 32-bit data. It keeps a one-shot prefix: a 32-bit prefix value and a prefix-active flag. Three kinds of prefix instruction load the prefix value: a base register plus a signed 8-bit displacement, a base register plus an index register scaled by the access size, or a double-indirect value. The double-indirect value is either a 32-bit inline word or a word read from memory. The memory instruction that follows takes the prefix value as its address in place of its source register. After that instruction retires, the prefix is gone.

The block also produces the base-register write-back for post-increment. It tells the core when an operand is an inline immediate in the instruction stream, and how many bytes that immediate takes. It masks the prefix flag out of a condition-code word that is about to be stored. The decoder supplies the operation kind, the instruction fields and two register-file read values, along with the current PC, the inline word following the instruction and the load data. The core raises `insn_retire` in the cycle the instruction completes. Only a retire changes the prefix state.

Top module: `pfx_agu`

## Requirements
- R1: After reset the prefix flag is low and the prefix value is zero.
- R2: For a memory access (`op` = 1) the request address is the prefix value when the prefix flag is set, and otherwise the source register value `rs_val`.
- R3: A memory access in post-increment mode without a prefix writes back the source register (`wb_idx` = `src_idx`) as `rs_val` plus 1, 2 or 4 for `size_code` 0, 1 or 2, with `wb_en` high only in the retire cycle.
- R4: A memory access in post-increment mode with the prefix active writes back the source register with the prefix value instead of incrementing it.
- R5: A memory access whose source index is 15 (the PC) with no prefix active is an inline immediate. `use_imm` is high, no memory request is made, no write-back occurs, and `imm_len` is 2, 2 or 4 for `size_code` 0, 1 or 2.
- R6: The displacement prefix (`op` = 2) loads the prefix with the register named by `dst_idx` plus the sign-extended `disp8`. When `dst_idx` is 15 it loads PC+2 plus the displacement.
- R7: The scaled-index prefix (`op` = 3) loads the prefix with `rs_val` plus `rd_val` shifted left by `size_code` (0, 1 or 2). When `src_idx` is 15 the base is ((PC+2) OR 1) + 1.
- R8: The double-indirect prefix (`op` = 4) with `src_idx` 15 loads `imm32` and reports `imm_len` 4. With any other source it requests a read at `rs_val`, loads the prefix from `mem_rdata`, and in post-increment mode writes back `rs_val`+4.
- R9: Retiring a prefix instruction sets the prefix flag. Retiring any other instruction clears it. Without a retire the flag and the value hold.
- R10: `ccr_store_val` equals `ccr_in` with bit `PFX_BIT` (default 11) forced to zero and every other bit passed through.
- R11: A scaled-index prefix with `size_code` 3 raises `illegal`. When it retires it leaves the prefix flag clear.
- R12: `ls_valid` is high only while `insn_valid` is high and the operation needs a data access: a non-immediate memory access or a double-indirect prefix from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | A decoded instruction is present |
| insn_retire | input | 1 | The present instruction completes this cycle |
| op | input | 3 | 0 other, 1 memory access, 2 displacement prefix, 3 scaled-index prefix, 4 double-indirect prefix |
| autoinc | input | 1 | Post-increment mode selected |
| size_code | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| src_idx | input | 4 | Source register field |
| dst_idx | input | 4 | Destination / base register field |
| rs_val | input | 32 | Value of the register named by src_idx |
| rd_val | input | 32 | Value of the register named by dst_idx |
| pc | input | 32 | Address of the present instruction |
| disp8 | input | 8 | Low byte of the instruction (signed displacement) |
| imm32 | input | 32 | Stream word following the instruction |
| mem_rdata | input | 32 | Load data for the double-indirect prefix |
| ls_ready | input | 1 | Load/store unit accepts the request |
| ccr_in | input | 32 | Condition-code word about to be stored |
| ls_valid | output | 1 | Data access request |
| ls_addr | output | 32 | Data access address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_idx | output | 4 | Base register written back |
| wb_val | output | 32 | Write-back value |
| use_imm | output | 1 | Operand is an inline immediate |
| imm_len | output | 3 | Extra stream bytes taken by the inline operand |
| illegal | output | 1 | Unsupported scale encoding |
| pfx_active | output | 1 | Prefix flag |
| pfx_value | output | 32 | Prefix value |
| ccr_store_val | output | 32 | Condition-code word with the prefix bit cleared |

## Verification
The assertions assume that the core retires an instruction only while `insn_valid` is high. They also assume that whenever a request is raised in the retire cycle, `ls_ready` is high in that same cycle. The bench keeps to this. It holds `ls_ready` high in every retire cycle. In the one scenario that holds `ls_ready` low, `insn_retire` stays low throughout. The bench also drives `mem_rdata` and `imm32` as steady values for the whole instruction, as a single-cycle load/store unit would.

// File: rtl/pfx_agu_pkg.sv
package pfx_agu_pkg;
  typedef enum logic [2:0] {
    OP_OTHER     = 3'd0,
    OP_MEM       = 3'd1,
    OP_PFX_DISP  = 3'd2,
    OP_PFX_INDEX = 3'd3,
    OP_PFX_INDIR = 3'd4
  } agu_op_e;

  localparam logic [1:0] SZ_ILLEGAL = 2'd3;
endpackage

// File: rtl/agu_prefix_reg.sv
module agu_prefix_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_i,
  input  logic          load_i,
  input  logic [DW-1:0] next_i,
  output logic          active_o,
  output logic [DW-1:0] value_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      value_o  <= '0;
    end else if (retire_i) begin
      active_o <= load_i;
      if (load_i) value_o <= next_i;
    end
  end

  assert_pfx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && load_i |=> active_o && (value_o == $past(next_i)));
  assert_pfx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && !load_i |=> !active_o);
  assert_pfx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> $stable(active_o) && $stable(value_o));
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import pfx_agu_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  agu_op_e       op_i,
  input  logic          valid_i,
  input  logic          autoinc_i,
  input  logic [1:0]    size_i,
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] dst_i,
  input  logic [DW-1:0] rs_i,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] pc_i,
  input  logic [7:0]    disp_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          pfx_active_i,
  input  logic [DW-1:0] pfx_value_i,
  output logic          ls_valid_o,
  output logic [DW-1:0] ls_addr_o,
  output logic          wb_want_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [DW-1:0] wb_val_o,
  output logic          use_imm_o,
  output logic [2:0]    imm_len_o,
  output logic          pfx_load_o,
  output logic [DW-1:0] pfx_next_o,
  output logic          illegal_o
);
  localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};

  function automatic logic [DW-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = DW'(1);
      2'd1:    size_bytes = DW'(2);
      default: size_bytes = DW'(4);
    endcase
  endfunction

  function automatic logic [2:0] stream_len(input logic [1:0] sz);
    stream_len = (sz == 2'd0 || sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [DW-1:0] pc_next(input logic [DW-1:0] pc);
    pc_next = pc + DW'(2);
  endfunction

  function automatic logic [DW-1:0] sext8(input logic [7:0] d);
    sext8 = {{(DW-8){d[7]}}, d};
  endfunction

  logic          is_pc_src;
  logic          ls_want;

  assign is_pc_src = (src_i == PC_IDX);

  always_comb begin
    ls_want    = 1'b0;
    ls_addr_o  = rs_i;
    wb_want_o  = 1'b0;
    wb_idx_o   = src_i;
    wb_val_o   = rs_i;
    use_imm_o  = 1'b0;
    imm_len_o  = 3'd0;
    pfx_load_o = 1'b0;
    pfx_next_o = pfx_value_i;
    illegal_o  = 1'b0;
    case (op_i)
      OP_MEM: begin
        use_imm_o = is_pc_src && !pfx_active_i;
        ls_addr_o = pfx_active_i ? pfx_value_i : rs_i;
        if (use_imm_o) imm_len_o = stream_len(size_i);
        else           ls_want   = 1'b1;
        if (autoinc_i && pfx_active_i) begin
          wb_want_o = 1'b1;
          wb_val_o  = pfx_value_i;
        end else if (autoinc_i && !use_imm_o) begin
          wb_want_o = 1'b1;
          wb_val_o  = rs_i + size_bytes(size_i);
        end
      end
      OP_PFX_DISP: begin
        pfx_load_o = 1'b1;
        pfx_next_o = ((dst_i == PC_IDX) ? pc_next(pc_i) : rd_i) + sext8(disp_i);
      end
      OP_PFX_INDEX: begin
        if (size_i == SZ_ILLEGAL) begin
          illegal_o = valid_i;
        end else begin
          pfx_load_o = 1'b1;
          pfx_next_o = (is_pc_src ? ((pc_next(pc_i) | DW'(1)) + DW'(1)) : rs_i)
                       + (rd_i << size_i);
        end
      end
      OP_PFX_INDIR: begin
        pfx_load_o = 1'b1;
        if (is_pc_src) begin
          pfx_next_o = imm_i;
          imm_len_o  = 3'd4;
        end else begin
          ls_want    = 1'b1;
          pfx_next_o = rdata_i;
          if (autoinc_i) begin
            wb_want_o = 1'b1;
            wb_val_o  = rs_i + DW'(4);
          end
        end
      end
      default: ;
    endcase
    ls_valid_o = valid_i && ls_want;
  end
endmodule

// File: rtl/pfx_agu.sv
module pfx_agu
  import pfx_agu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int RW      = 4,
  parameter int PFX_BIT = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic          insn_retire,
  input  logic [2:0]    op,
  input  logic          autoinc,
  input  logic [1:0]    size_code,
  input  logic [RW-1:0] src_idx,
  input  logic [RW-1:0] dst_idx,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] pc,
  input  logic [7:0]    disp8,
  input  logic [DW-1:0] imm32,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ls_ready,
  input  logic [DW-1:0] ccr_in,
  output logic          ls_valid,
  output logic [DW-1:0] ls_addr,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_val,
  output logic          use_imm,
  output logic [2:0]    imm_len,
  output logic          illegal,
  output logic          pfx_active,
  output logic [DW-1:0] pfx_value,
  output logic [DW-1:0] ccr_store_val
);
  localparam logic [DW-1:0] PFX_MASK = DW'(1) << PFX_BIT;

  agu_op_e       op_e;
  logic          wb_want;
  logic          pfx_load;
  logic [DW-1:0] pfx_next;

  assign op_e = agu_op_e'(op);

  agu_addr_calc #(.DW(DW), .RW(RW)) u_calc (
    .op_i(op_e), .valid_i(insn_valid), .autoinc_i(autoinc), .size_i(size_code),
    .src_i(src_idx), .dst_i(dst_idx), .rs_i(rs_val), .rd_i(rd_val), .pc_i(pc),
    .disp_i(disp8), .imm_i(imm32), .rdata_i(mem_rdata),
    .pfx_active_i(pfx_active), .pfx_value_i(pfx_value),
    .ls_valid_o(ls_valid), .ls_addr_o(ls_addr), .wb_want_o(wb_want),
    .wb_idx_o(wb_idx), .wb_val_o(wb_val), .use_imm_o(use_imm),
    .imm_len_o(imm_len), .pfx_load_o(pfx_load), .pfx_next_o(pfx_next),
    .illegal_o(illegal)
  );

  agu_prefix_reg #(.DW(DW)) u_pfx (
    .clk(clk), .rst_n(rst_n), .retire_i(insn_retire), .load_i(pfx_load),
    .next_i(pfx_next), .active_o(pfx_active), .value_o(pfx_value)
  );

  assign wb_en         = insn_retire && wb_want;
  assign ccr_store_val = ccr_in & ~PFX_MASK;

  assert_addr_from_pfx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_valid && (op_e == OP_MEM) && pfx_active |-> ls_addr == pfx_value);
  assert_imm_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm |-> !ls_valid);
  assert_illegal_no_pfx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    insn_retire && illegal |=> !pfx_active);
  assert_retire_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    insn_retire && ls_valid |-> ls_ready);
  assert_retire_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    insn_retire |-> insn_valid);
endmodule

// File: tb/tb_pfx_agu.sv
module tb_pfx_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid, insn_retire, autoinc, ls_ready;
  logic [2:0]  op;
  logic [1:0]  size_code;
  logic [3:0]  src_idx, dst_idx;
  logic [31:0] rs_val, rd_val, pc, imm32, mem_rdata, ccr_in;
  logic [7:0]  disp8;
  logic        ls_valid, wb_en, use_imm, illegal, pfx_active;
  logic [31:0] ls_addr, wb_val, pfx_value, ccr_store_val;
  logic [3:0]  wb_idx;
  logic [2:0]  imm_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfx_agu dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    insn_valid = 0; insn_retire = 0; op = 3'd0; autoinc = 0; size_code = 2'd2;
    src_idx = 4'd1; dst_idx = 4'd2; rs_val = 32'h0; rd_val = 32'h0; pc = 32'h0;
    disp8 = 8'h0; imm32 = 32'h0; mem_rdata = 32'h0; ls_ready = 1; ccr_in = 32'h0;
  endtask

  task automatic issue(input logic [2:0] o, input logic ai, input logic [1:0] sz,
                       input logic [3:0] s, input logic [3:0] d, input logic ret);
    @(negedge clk);
    idle();
    insn_valid = 1; op = o; autoinc = ai; size_code = sz; src_idx = s; dst_idx = d;
    insn_retire = ret;
  endtask

  task automatic finish_insn();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic set_prefix(input logic [31:0] v);
    issue(3'd4, 0, 2'd2, 4'd15, 4'd0, 1);
    imm32 = v;
    finish_insn();
  endtask

  task automatic t_reset();
    chk("R1 flag", {31'b0, pfx_active}, 32'd0);
    chk("R1 value", pfx_value, 32'd0);
  endtask

  task automatic t_plain_addr();
    issue(3'd1, 0, 2'd2, 4'd3, 4'd4, 1);
    rs_val = 32'h0000_4000; #1;
    chk("R2 addr plain", ls_addr, 32'h4000);
    chk("R12 valid", {31'b0, ls_valid}, 32'd1);
    chk("R3 no wb without autoinc", {31'b0, wb_en}, 32'd0);
    finish_insn();
  endtask

  task automatic t_autoinc();
    for (int sz = 0; sz < 3; sz++) begin
      issue(3'd1, 1, sz[1:0], 4'd5, 4'd0, 0);
      rs_val = 32'h100; #1;
      chk("R3 wb hidden before retire", {31'b0, wb_en}, 32'd0);
      insn_retire = 1; #1;
      chk("R3 wb_en", {31'b0, wb_en}, 32'd1);
      chk("R3 wb_idx", {28'b0, wb_idx}, 32'd5);
      chk("R3 wb_val", wb_val, 32'h100 + (32'd1 << sz));
      finish_insn();
    end
  endtask

  task automatic t_imm();
    for (int sz = 0; sz < 3; sz++) begin
      issue(3'd1, 1, sz[1:0], 4'd15, 4'd0, 1);
      #1;
      chk("R5 use_imm", {31'b0, use_imm}, 32'd1);
      chk("R5 no request", {31'b0, ls_valid}, 32'd0);
      chk("R5 no wb", {31'b0, wb_en}, 32'd0);
      chk("R5 imm_len", {29'b0, imm_len}, (sz == 2) ? 32'd4 : 32'd2);
      finish_insn();
    end
  endtask

  task automatic t_disp();
    issue(3'd2, 0, 2'd0, 4'd0, 4'd6, 1);
    rd_val = 32'h1000; disp8 = 8'hF0;
    finish_insn();
    chk("R6 reg base", pfx_value, 32'h0FF0);
    chk("R9 set by prefix", {31'b0, pfx_active}, 32'd1);
    issue(3'd2, 0, 2'd0, 4'd0, 4'd15, 1);
    pc = 32'h200; disp8 = 8'h10; rd_val = 32'hDEAD;
    finish_insn();
    chk("R6 pc base", pfx_value, 32'h212);
  endtask

  task automatic t_index();
    issue(3'd3, 0, 2'd2, 4'd7, 4'd8, 1);
    rs_val = 32'h2000; rd_val = 32'h3;
    finish_insn();
    chk("R7 scale 4", pfx_value, 32'h200C);
    issue(3'd3, 0, 2'd1, 4'd15, 4'd8, 1);
    pc = 32'h100; rd_val = 32'h5;
    finish_insn();
    chk("R7 pc base", pfx_value, 32'h10E);
  endtask

  task automatic t_indir();
    issue(3'd4, 0, 2'd2, 4'd15, 4'd0, 1);
    imm32 = 32'hCAFE_0000; #1;
    chk("R8 imm_len", {29'b0, imm_len}, 32'd4);
    finish_insn();
    chk("R8 imm prefix", pfx_value, 32'hCAFE_0000);
    issue(3'd4, 1, 2'd2, 4'd9, 4'd0, 1);
    rs_val = 32'h800; mem_rdata = 32'h1234_5678; #1;
    chk("R8 read addr", ls_addr, 32'h800);
    chk("R12 indirect request", {31'b0, ls_valid}, 32'd1);
    chk("R8 wb", wb_val, 32'h804);
    finish_insn();
    chk("R8 mem prefix", pfx_value, 32'h1234_5678);
  endtask

  task automatic t_prefixed_mem();
    set_prefix(32'h0000_ABC0);
    issue(3'd1, 1, 2'd0, 4'd15, 4'd0, 1);
    rs_val = 32'h10; #1;
    chk("R2 addr from prefix", ls_addr, 32'hABC0);
    chk("R5 pc src with prefix not imm", {31'b0, use_imm}, 32'd0);
    chk("R4 wb prefix", wb_val, 32'hABC0);
    chk("R4 wb_en", {31'b0, wb_en}, 32'd1);
    finish_insn();
    chk("R9 cleared by retire", {31'b0, pfx_active}, 32'd0);
  endtask

  task automatic t_hold();
    set_prefix(32'h55);
    issue(3'd1, 0, 2'd2, 4'd3, 4'd0, 0);
    ls_ready = 0; rs_val = 32'h9;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9 hold without retire", {31'b0, pfx_active}, 32'd1);
    chk("R9 value hold", pfx_value, 32'h55);
    idle(); #1;
    chk("R12 no request when invalid", {31'b0, ls_valid}, 32'd0);
    issue(3'd0, 0, 2'd2, 4'd3, 4'd0, 1);
    finish_insn();
    chk("R9 other op clears", {31'b0, pfx_active}, 32'd0);
  endtask

  task automatic t_illegal();
    issue(3'd3, 0, 2'd3, 4'd1, 4'd2, 1);
    #1;
    chk("R11 illegal", {31'b0, illegal}, 32'd1);
    finish_insn();
    chk("R11 no prefix", {31'b0, pfx_active}, 32'd0);
  endtask

  task automatic t_ccr();
    @(negedge clk);
    ccr_in = 32'hFFFF_FFFF; #1;
    chk("R10 mask all ones", ccr_store_val, 32'hFFFF_F7FF);
    ccr_in = 32'h0000_0805; #1;
    chk("R10 mask mixed", ccr_store_val, 32'h0000_0005);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_plain_addr();
    t_autoinc();
    t_imm();
    t_disp();
    t_index();
    t_indir();
    t_prefixed_mem();
    t_hold();
    t_illegal();
    t_ccr();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule